// File: doc/BRIEF.md
# NOR Flash Command Sequence Decoder

This block sits beside the write path of a parallel NOR flash bus that has a 21-bit word address and 16-bit data. It watches each write cycle and recognises the multi-write command sequences a host uses to drive the flash. A standard sequence opens with two unlock writes and then gives a command code. A shortcut mode drops the unlock writes. The block does not touch the array or the program and erase timing. It reports each recognised command as a one-cycle pulse, and a program pulse carries the address and data it captured with it. The block also holds the state that later commands depend on: the current read mode, whether the shortcut mode is active, a lock bit for each 4K-word sector, and a 2-bit wait count.

The program and erase engines drive two status inputs: busy, and erase-in-progress. The decoder uses them to gate commands, to decide when an erase may be suspended, and to decide when a write is ignored. In identification mode the decoder also answers reads on the read port with identification words and the lock status of a sector.

Every decision is taken at the clock edge that samples `wrEn`. Pulses, mode changes and register updates are visible in the cycle after that edge.

Top module: `nor_seq_decoder`

## Requirements
- R1: After reset all pulses are 0, `readMode` is 0 (array read), `bypassMode` is 0, `waitCount` is 0, and every sector is locked.
- R2: The writes 00AAh to address[10:0]=555h, then 0055h to address[10:0]=2AAh, then 0090h to address[10:0]=555h set `readMode` to 1 (identification). Only data bits 7:0 are decoded, and address bits 20:11 are ignored while the sequence is decoded.
- R3: While `readMode`=1, `rdData` depends on the offset `rdAddr[11:0]`. Offset 000h gives 0001h and offset 001h gives 22D1h. Offset 002h gives 0001h when the sector `rdAddr[20:12]` is locked and 0000h when it is unlocked. Offset 003h gives 0021h when `revLatency`=1 and 0000h when it is 0. Any other offset gives 0. In every other read mode `rdData` is 0.
- R4: After unlock and A0h, the fourth write produces `pgmPulse` with `cmdAddr` and `cmdData` equal to that write's address and data.
- R5: Unlock, 80h, unlock, then 10h to address 555h produces `chipErasePulse`. The same sequence with 30h as the last write produces `sectorErasePulse`, and `cmdAddr` then equals that write's address.
- R6: Three writes of 60h produce `lockPulse`. Bit 6 of the third write's address gives the new state of sector address[20:12]: 1 unlocks it and 0 locks it. `lockSet` shows 1 when the sector was locked. A hardware reset locks every sector again.
- R7: A program or sector erase aimed at a locked sector produces no pulse.
- R8: Unlock and then 20h sets `bypassMode`. In that mode, A0h followed by the address and data write programs. 80h followed by 30h to a sector erases that sector, and 80h followed by 10h erases the chip. 90h followed by 00h clears `bypassMode`.
- R9: A write of F0h to any address produces `resetPulse` and drops any partial sequence. `readMode` becomes 2 if an erase is suspended and 0 otherwise.
- R10: B0h gives `suspendPulse` and sets `readMode` to 2, but only while `eraseActive`=1 and no erase is suspended. 30h gives `resumePulse` and sets `readMode` to 0, but only while an erase is suspended.
- R11: Unlock and then C0h gives `setWaitPulse` and loads `waitCount` from address bits 13:12 of that write. Unlock and then 70h gives `powerSavePulse`.
- R12: A write that does not fit the next step of a sequence returns the decoder to idle and does not change `readMode`.
- R13: While `busy`=1, every write other than F0h and an accepted B0h is ignored. It produces no pulse and changes no mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low hardware reset |
| wrEn | input | 1 | One-cycle write strobe |
| wrAddr | input | 21 | Write word address |
| wrData | input | 16 | Write data |
| busy | input | 1 | Program or erase engine busy |
| eraseActive | input | 1 | A sector erase is running |
| revLatency | input | 1 | Selects the word returned at offset 003h |
| rdAddr | input | 21 | Read word address |
| rdData | output | 16 | Identification read data |
| readMode | output | 2 | 0 array, 1 identification, 2 erase-suspend read |
| bypassMode | output | 1 | Shortcut (unlock bypass) mode active |
| waitCount | output | 2 | Wait count last set |
| cmdAddr | output | 21 | Address captured with a command |
| cmdData | output | 16 | Program data |
| lockSet | output | 1 | Lock state written by the last lock command |
| pgmPulse | output | 1 | Program command |
| chipErasePulse | output | 1 | Chip erase command |
| sectorErasePulse | output | 1 | Sector erase command |
| suspendPulse | output | 1 | Erase suspend |
| resumePulse | output | 1 | Erase resume |
| resetPulse | output | 1 | Reset command |
| lockPulse | output | 1 | Sector lock or unlock |
| setWaitPulse | output | 1 | Wait count loaded |
| powerSavePulse | output | 1 | Power-save mode requested |

## Verification
Two functions can claim the same write. A 30h write is both the resume code and the last step of a sector erase, and a B0h or F0h can arrive under busy while a sequence is half done. The bench provokes the first case by putting the decoder in identification mode while an erase is suspended and then writing 30h. It expects only `resumePulse` and a return to array read. It provokes the second by opening a sequence with busy high and checking that neither the pulses nor `readMode` move. Random lock, program, erase and status reads are compared against a lock model that the bench keeps itself.

// File: rtl/nor_seq_pkg.sv
package nor_seq_pkg;

  typedef enum logic [1:0] {
    RM_ARRAY   = 2'd0,
    RM_AUTOSEL = 2'd1,
    RM_SUSPEND = 2'd2
  } readMode_t;

  typedef enum logic [3:0] {
    SQ_IDLE, SQ_UNL1, SQ_UNL2, SQ_PGM,
    SQ_ER1, SQ_ER2, SQ_ER3, SQ_BER, SQ_BEXIT,
    SQ_LK1, SQ_LK2
  } seqState_t;

  typedef struct packed {
    logic pgm;
    logic chipErase;
    logic sectorErase;
    logic suspend;
    logic resume;
    logic reset;
    logic lockWr;
    logic setWait;
    logic powerSave;
  } cmdStrobes_t;

endpackage

// File: rtl/nor_seq_ctrl.sv
module nor_seq_ctrl
  import nor_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [10:0] wrLow,
  input  logic [7:0]  wrCode,
  input  logic        busy,
  input  logic        eraseActive,
  output cmdStrobes_t strobes,
  output readMode_t   readMode,
  output logic        bypass
);
  localparam logic [10:0] KEY_A = 11'h555;
  localparam logic [10:0] KEY_B = 11'h2AA;

  seqState_t state, nextState;
  readMode_t nextMode;
  logic      suspended, nextSusp, nextBypass;
  logic      atA, atB;

  assign atA = (wrLow == KEY_A);
  assign atB = (wrLow == KEY_B);

  always_comb begin
    nextState  = state;
    nextMode   = readMode;
    nextSusp   = suspended;
    nextBypass = bypass;
    strobes    = '0;
    if (wrEn) begin
      if (wrCode == 8'hF0) begin
        strobes.reset = 1'b1;
        nextState     = SQ_IDLE;
        nextMode      = suspended ? RM_SUSPEND : RM_ARRAY;
      end else if (wrCode == 8'hB0 && eraseActive && !suspended) begin
        strobes.suspend = 1'b1;
        nextSusp        = 1'b1;
        nextMode        = RM_SUSPEND;
        nextState       = SQ_IDLE;
      end else if (busy) begin
        nextState = state;
      end else if (wrCode == 8'h30 && suspended) begin
        strobes.resume = 1'b1;
        nextSusp       = 1'b0;
        nextMode       = RM_ARRAY;
        nextState      = SQ_IDLE;
      end else begin
        nextState = SQ_IDLE;
        case (state)
          SQ_IDLE: begin
            if (bypass) begin
              case (wrCode)
                8'hA0:   nextState = SQ_PGM;
                8'h80:   nextState = SQ_BER;
                8'h90:   nextState = SQ_BEXIT;
                8'h60:   nextState = SQ_LK1;
                default: nextState = SQ_IDLE;
              endcase
            end else if (wrCode == 8'hAA && atA) nextState = SQ_UNL1;
            else if (wrCode == 8'h60) nextState = SQ_LK1;
          end
          SQ_UNL1: if (wrCode == 8'h55 && atB) nextState = SQ_UNL2;
          SQ_UNL2: if (atA) begin
            case (wrCode)
              8'h90:   nextMode = RM_AUTOSEL;
              8'hA0:   nextState = SQ_PGM;
              8'h20:   nextBypass = 1'b1;
              8'hC0:   strobes.setWait = 1'b1;
              8'h70:   strobes.powerSave = 1'b1;
              8'h80:   nextState = SQ_ER1;
              default: nextState = SQ_IDLE;
            endcase
          end
          SQ_PGM:  strobes.pgm = 1'b1;
          SQ_ER1:  if (wrCode == 8'hAA && atA) nextState = SQ_ER2;
          SQ_ER2:  if (wrCode == 8'h55 && atB) nextState = SQ_ER3;
          SQ_ER3: begin
            if (wrCode == 8'h10 && atA) strobes.chipErase = 1'b1;
            else if (wrCode == 8'h30) strobes.sectorErase = 1'b1;
          end
          SQ_BER: begin
            if (wrCode == 8'h10) strobes.chipErase = 1'b1;
            else if (wrCode == 8'h30) strobes.sectorErase = 1'b1;
          end
          SQ_BEXIT: if (wrCode == 8'h00) nextBypass = 1'b0;
          SQ_LK1:  if (wrCode == 8'h60) nextState = SQ_LK2;
          SQ_LK2:  if (wrCode == 8'h60) strobes.lockWr = 1'b1;
          default: nextState = SQ_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= SQ_IDLE;
      readMode  <= RM_ARRAY;
      suspended <= 1'b0;
      bypass    <= 1'b0;
    end else begin
      state     <= nextState;
      readMode  <= nextMode;
      suspended <= nextSusp;
      bypass    <= nextBypass;
    end
  end

  // R13
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && busy && wrCode != 8'hF0 && wrCode != 8'hB0)
      |=> ($stable(state) && $stable(readMode) && $stable(bypass)));

  // R9
  reset_cmd_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrCode == 8'hF0) |=> (state == SQ_IDLE && readMode != RM_AUTOSEL));

  // R8
  bypass_entry_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(bypass) |-> $past(wrEn && wrCode == 8'h20 && !busy));
endmodule

// File: rtl/nor_seq_dp.sv
module nor_seq_dp
  import nor_seq_pkg::*;
#(
  parameter int ADDR_W   = 21,
  parameter int DATA_W   = 16,
  parameter int SECT_LSB = 12,
  parameter int WAIT_LSB = 12,
  parameter int LOCK_BIT = 6,
  parameter logic [DATA_W-1:0] MFR_WORD = 16'h0001,
  parameter logic [DATA_W-1:0] DEV_WORD = 16'h22D1,
  parameter logic [DATA_W-1:0] LAT_WORD = 16'h0021
)(
  input  logic              clk,
  input  logic              rstN,
  input  cmdStrobes_t       strobes,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  readMode_t         readMode,
  input  logic              revLatency,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic [1:0]        waitCount,
  output logic [ADDR_W-1:0] cmdAddr,
  output logic [DATA_W-1:0] cmdData,
  output logic              lockSet,
  output logic [8:0]        pulses
);
  localparam int SECT_W   = ADDR_W - SECT_LSB;
  localparam int NUM_SECT = 1 << SECT_W;
  localparam int OFF_W    = SECT_LSB;

  logic [NUM_SECT-1:0] lockBits;
  logic [SECT_W-1:0]   wrSect, rdSect, cmdSect;
  logic [OFF_W-1:0]    rdOff;
  logic                wrLocked;

  assign wrSect   = wrAddr[ADDR_W-1:SECT_LSB];
  assign rdSect   = rdAddr[ADDR_W-1:SECT_LSB];
  assign rdOff    = rdAddr[OFF_W-1:0];
  assign cmdSect  = cmdAddr[ADDR_W-1:SECT_LSB];
  assign wrLocked = lockBits[wrSect];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lockBits  <= '1;
      pulses    <= '0;
      cmdAddr   <= '0;
      cmdData   <= '0;
      lockSet   <= 1'b0;
      waitCount <= '0;
    end else begin
      pulses <= {strobes.pgm && !wrLocked, strobes.chipErase,
                 strobes.sectorErase && !wrLocked, strobes.suspend,
                 strobes.resume, strobes.reset, strobes.lockWr,
                 strobes.setWait, strobes.powerSave};
      if (|strobes) cmdAddr <= wrAddr;
      if (strobes.pgm) cmdData <= wrData;
      if (strobes.lockWr) begin
        lockBits[wrSect] <= !wrAddr[LOCK_BIT];
        lockSet          <= !wrAddr[LOCK_BIT];
      end
      if (strobes.setWait) waitCount <= wrAddr[WAIT_LSB+1:WAIT_LSB];
    end
  end

  always_comb begin
    rdData = '0;
    if (readMode == RM_AUTOSEL) begin
      if (rdOff == OFF_W'(0))      rdData = MFR_WORD;
      else if (rdOff == OFF_W'(1)) rdData = DEV_WORD;
      else if (rdOff == OFF_W'(2)) rdData = DATA_W'(lockBits[rdSect]);
      else if (rdOff == OFF_W'(3)) rdData = revLatency ? LAT_WORD : '0;
    end
  end

  // R5
  one_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(pulses));

  // R7
  erase_unlocked_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pulses[8] || pulses[6]) |-> !lockBits[cmdSect]);

  // R6
  lock_state_chk: assert property (@(posedge clk) disable iff (!rstN)
    pulses[2] |-> (lockBits[cmdSect] == lockSet));
endmodule

// File: rtl/nor_seq_decoder.sv
module nor_seq_decoder
  import nor_seq_pkg::*;
#(
  parameter int ADDR_W   = 21,
  parameter int DATA_W   = 16,
  parameter int SECT_LSB = 12
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              busy,
  input  logic              eraseActive,
  input  logic              revLatency,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic [1:0]        readMode,
  output logic              bypassMode,
  output logic [1:0]        waitCount,
  output logic [ADDR_W-1:0] cmdAddr,
  output logic [DATA_W-1:0] cmdData,
  output logic              lockSet,
  output logic              pgmPulse,
  output logic              chipErasePulse,
  output logic              sectorErasePulse,
  output logic              suspendPulse,
  output logic              resumePulse,
  output logic              resetPulse,
  output logic              lockPulse,
  output logic              setWaitPulse,
  output logic              powerSavePulse
);
  cmdStrobes_t strobes;
  readMode_t   modeInt;
  logic [8:0]  pulses;

  nor_seq_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrLow(wrAddr[10:0]),
    .wrCode(wrData[7:0]), .busy(busy), .eraseActive(eraseActive),
    .strobes(strobes), .readMode(modeInt), .bypass(bypassMode)
  );

  nor_seq_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SECT_LSB(SECT_LSB)) i_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrAddr(wrAddr),
    .wrData(wrData), .readMode(modeInt), .revLatency(revLatency),
    .rdAddr(rdAddr), .rdData(rdData), .waitCount(waitCount),
    .cmdAddr(cmdAddr), .cmdData(cmdData), .lockSet(lockSet),
    .pulses(pulses)
  );

  assign readMode = modeInt;
  assign {pgmPulse, chipErasePulse, sectorErasePulse, suspendPulse,
          resumePulse, resetPulse, lockPulse, setWaitPulse,
          powerSavePulse} = pulses;
endmodule

// File: tb/test_nor_seq_decoder.sv
module test_nor_seq_decoder;
  logic clk = 1'b0, rstN = 1'b0, wrEn = 1'b0;
  logic [20:0] wrAddr = '0, rdAddr = '0, cmdAddr;
  logic [15:0] wrData = '0, rdData, cmdData;
  logic busy = 1'b0, eraseActive = 1'b0, revLatency = 1'b0;
  logic [1:0] readMode, waitCount;
  logic bypassMode, lockSet;
  logic pgmP, chipP, secP, susP, resP, rstP, lockP, waitP, psP;
  logic [8:0] pv;
  logic [511:0] lockModel = '1;
  int tests = 0, fails = 0;

  localparam logic [8:0] P_PGM = 9'h100, P_CHIP = 9'h080, P_SEC = 9'h040,
    P_SUS = 9'h020, P_RES = 9'h010, P_RST = 9'h008, P_LOCK = 9'h004,
    P_WAIT = 9'h002, P_PS = 9'h001;

  always #2.5 clk = ~clk;

  nor_seq_decoder i_nor_seq_decoder (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .busy(busy), .eraseActive(eraseActive), .revLatency(revLatency),
    .rdAddr(rdAddr), .rdData(rdData), .readMode(readMode),
    .bypassMode(bypassMode), .waitCount(waitCount), .cmdAddr(cmdAddr),
    .cmdData(cmdData), .lockSet(lockSet), .pgmPulse(pgmP),
    .chipErasePulse(chipP), .sectorErasePulse(secP), .suspendPulse(susP),
    .resumePulse(resP), .resetPulse(rstP), .lockPulse(lockP),
    .setWaitPulse(waitP), .powerSavePulse(psP)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [20:0] a, input logic [15:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
    pv = {pgmP, chipP, secP, susP, resP, rstP, lockP, waitP, psP};
  endtask

  task automatic unl();
    wr(21'h000555, 16'h00AA);
    wr(21'h0002AA, 16'h0055);
  endtask

  task automatic rd(input logic [20:0] a);
    rdAddr = a;
    #0.5;
  endtask

  function automatic logic [20:0] sa(input logic [8:0] s, input logic [11:0] off);
    return {s, off};
  endfunction

  function automatic logic [15:0] expLock(input logic [8:0] s);
    return {15'b0, lockModel[s]};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    pv = {pgmP, chipP, secP, susP, resP, rstP, lockP, waitP, psP};
    chk("R1 pulses", pv, 0);
    chk("R1 readMode", readMode, 0);
    chk("R1 bypass", bypassMode, 0);
    chk("R1 waitCount", waitCount, 0);

    // R2: upper bytes and upper address bits are junk
    wr(21'h1FF555, 16'hFFAA); wr(21'h0A42AA, 16'h1255); wr(21'h180555, 16'h3C90);
    chk("R2 autoselect", readMode, 1);
    rd(21'h000000); chk("R3 off0", rdData, 16'h0001);
    rd(21'h000001); chk("R3 off1", rdData, 16'h22D1);
    rd(21'h000003); chk("R3 off3 lat0", rdData, 16'h0000);
    revLatency = 1'b1; rd(21'h000003); chk("R3 off3 lat1", rdData, 16'h0021);
    rd(sa(9'd5, 12'h002)); chk("R1 R3 sector locked", rdData, 16'h0001);
    rd(21'h000004); chk("R3 other", rdData, 0);

    wr(21'h012345, 16'h00F0);
    chk("R9 reset pulse", pv, P_RST);
    chk("R9 readMode", readMode, 0);
    rd(21'h000001); chk("R3 array read", rdData, 0);

    unl(); wr(21'h000555, 16'h00A0); wr(sa(9'd5, 12'h123), 16'hBEEF);
    chk("R7 locked program", pv, 0);

    wr(21'h0, 16'h0060); wr(21'h0, 16'h0060); wr(sa(9'd5, 12'h040), 16'h0060);
    lockModel[5] = 1'b0;
    chk("R6 lock pulse", pv, P_LOCK);
    chk("R6 lockSet", lockSet, 0);

    unl(); wr(21'h000555, 16'h00A0); wr(sa(9'd5, 12'h123), 16'hBEEF);
    chk("R4 program pulse", pv, P_PGM);
    chk("R4 cmdAddr", cmdAddr, sa(9'd5, 12'h123));
    chk("R4 cmdData", cmdData, 16'hBEEF);

    unl(); wr(21'h555, 16'h80); unl(); wr(sa(9'd5, 12'h0), 16'h0030);
    chk("R5 sector erase", pv, P_SEC);
    chk("R5 cmdAddr", cmdAddr, sa(9'd5, 12'h0));
    unl(); wr(21'h555, 16'h80); unl(); wr(sa(9'd6, 12'h0), 16'h0030);
    chk("R7 locked sector erase", pv, 0);
    unl(); wr(21'h555, 16'h80); unl(); wr(21'h555, 16'h0010);
    chk("R5 chip erase", pv, P_CHIP);

    // R12: bad third write, then a lone A0 must not program
    unl(); wr(21'h555, 16'h0012); chk("R12 bad code", pv, 0);
    wr(21'h555, 16'h00A0); wr(sa(9'd5, 12'h7), 16'h1111);
    chk("R12 sequence dropped", pv, 0);
    unl(); wr(21'h555, 16'h90); wr(21'h555, 16'h0055);
    chk("R12 mode kept", readMode, 1);
    wr(21'h0, 16'hF0);

    unl(); wr(21'h002555, 16'h00C0);
    chk("R11 wait pulse", pv, P_WAIT);
    chk("R11 waitCount", waitCount, 2);
    unl(); wr(21'h000555, 16'h0070);
    chk("R11 power save", pv, P_PS);

    unl(); wr(21'h555, 16'h0020);
    chk("R8 bypass on", bypassMode, 1);
    wr(21'h0, 16'hA0); wr(sa(9'd5, 12'h200), 16'h1234);
    chk("R8 bypass program", pv, P_PGM);
    chk("R8 bypass data", cmdData, 16'h1234);
    wr(21'h0, 16'h80); wr(sa(9'd5, 12'h0), 16'h30);
    chk("R8 bypass sector erase", pv, P_SEC);
    wr(21'h0, 16'h80); wr(21'h0, 16'h10);
    chk("R8 bypass chip erase", pv, P_CHIP);
    wr(21'h180000, 16'h90); wr(21'h0, 16'h00);
    chk("R8 bypass off", bypassMode, 0);

    eraseActive = 1'b1; busy = 1'b1;
    wr(21'h180000, 16'h00B0);
    chk("R10 suspend pulse", pv, P_SUS);
    chk("R10 suspend mode", readMode, 2);
    unl(); wr(21'h555, 16'h90);
    chk("R13 busy no pulse", pv, 0);
    chk("R13 busy mode kept", readMode, 2);
    wr(21'h0, 16'hB0);
    chk("R10 second suspend", pv, 0);
    busy = 1'b0;
    unl(); wr(21'h555, 16'h90);
    chk("R2 autoselect in suspend", readMode, 1);
    wr(21'h0, 16'h30);
    chk("R10 resume wins over erase step", pv, P_RES);
    chk("R10 resume mode", readMode, 0);
    wr(21'h0, 16'hB0); wr(21'h0, 16'hB0 - 16'h0);
    wr(21'h0, 16'h00B0);
    unl(); wr(21'h555, 16'h90); wr(21'h0, 16'hF0);
    chk("R9 back to suspend read", readMode, 2);
    wr(21'h0, 16'h30); chk("R10 resume", pv, P_RES);
    wr(21'h0, 16'h30); chk("R10 resume not suspended", pv, 0);
    eraseActive = 1'b0;
    wr(21'h0, 16'hB0); chk("R10 suspend without erase", pv, 0);

    for (int i = 0; i < 60; i++) begin
      logic [8:0] s;
      logic [11:0] off;
      logic [15:0] d;
      int op;
      s = 9'($urandom % 512);
      off = 12'($urandom % 4096);
      d = 16'($urandom);
      op = $urandom % 4;
      if (i < 8) s = 9'(i);
      case (op)
        0: begin
          logic ul;
          ul = 1'($urandom % 2);
          wr(21'h0, 16'h60); wr(21'h0, 16'h60); wr(sa(s, {5'b0, ul, 6'b0}), 16'h60);
          lockModel[s] = !ul;
          chk("R6 random lock", pv, P_LOCK);
        end
        1: begin
          unl(); wr(21'h555, 16'hA0); wr(sa(s, off), d);
          chk("R7 random program", pv, lockModel[s] ? 9'h0 : P_PGM);
        end
        2: begin
          unl(); wr(21'h555, 16'h80); unl(); wr(sa(s, off), 16'h30);
          chk("R7 random sector erase", pv, lockModel[s] ? 9'h0 : P_SEC);
        end
        default: begin
          unl(); wr(21'h555, 16'h90);
          rd(sa(s, 12'h002));
          chk("R3 random lock status", rdData, expLock(s));
          wr(21'h0, 16'hF0);
        end
      endcase
    end

    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
    chk("R1 waitCount after reset", waitCount, 0);
    unl(); wr(21'h555, 16'h90);
    rd(sa(9'd5, 12'h002));
    chk("R6 relocked by reset", rdData, 16'h0001);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule